// File: doc/BRIEF.md
# MDIO management controller

This block is a clause 22 MDIO management master for one Ethernet MAC. Software loads a management command into four byte-wide command registers. The command holds the PHY address, the PHY register number, the read/write select and, for a write, 16 bits of data. Software then sets a start bit. The block produces the MDC clock, shifts out a 64-bit management frame on MDIO and, for a read, releases the line and samples the PHY's reply.

Completion is reported by the start bit, which clears on its own when the frame ends. A read leaves its 16-bit result in two byte-wide status registers. A third status register carries a flag that is set when the PHY did not pull the line low in the second turnaround bit.

A control register holds two bits:
- an MDC enable;
- a core reset, which aborts any frame in progress.

MDC is derived from the system clock by a parameterised half-period divider. The default is 50 system clocks per half period, which gives 2.5 MHz at 250 MHz. MDIO changes only as MDC falls and is sampled as MDC rises.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset:
  - all command bytes and status bytes read 0x00;
  - the control register (address 8) reads 0x10, meaning MDC enabled and core reset clear;
  - mdio_oe is 0.
- R2: Command registers are at addresses 0 to 3 and read back what was written:
  - byte 0 holds write data bits 7:0;
  - byte 1 holds write data bits 15:8;
  - byte 2 holds the register number in bits 4:0 and PHY address bits 2:0 in bits 7:5;
  - byte 3 holds PHY address bits 4:3 in bits 1:0, write select (1 = write) in bit 2 and the start bit in bit 7;
  - bits 6:3 of byte 3 read 0.
- R3: MDC behaviour depends on the control register:
  - while control bit 4 is 1 and bit 0 is 0, MDC toggles every HALF_DIV system clocks, starting low after reset;
  - otherwise MDC is held low;
  - only bits 4 and 0 of the control register are stored; its other bits read 0.
- R4: A write frame is driven for 64 MDC periods with mdio_oe high throughout. The bits, in transmit order, are:
  - 32 ones;
  - 01;
  - opcode 01;
  - PHY address, MSB first;
  - register number, MSB first;
  - turnaround 10;
  - the 16 data bits, MSB first.
- R5: A read frame uses opcode 10 and drives its first 46 bits as for a write. mdio_oe is low for the last 18 bits. The 16 bits sampled after the turnaround are stored MSB first: bits 15:8 in status byte 1 (address 5) and bits 7:0 in status byte 0 (address 4).
- R6: Status byte 3 (address 7) bit 7 is the read-failed flag:
  - it is set when the second turnaround bit of a read is sampled as 1;
  - it is cleared at the start of every read;
  - write frames leave it unchanged.
- R7: The start bit reads 1 from the write that sets it until the falling MDC edge that ends the 64th bit period, which comes HALF_DIV clocks after the 64th rising edge.
- R8: While the start bit reads 1, writes to command bytes 0 to 3 have no effect, neither on their readback nor on the frame being sent.
- R9: Setting control bit 0 (core reset) aborts a frame within one clock:
  - the start bit reads 0, mdio_oe is 0 and MDC is low;
  - while core reset is set, writing the start bit does not start a frame.
- R10: mdio_o and mdio_oe never change while MDC stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address (0-3 command, 4-7 status, 8 control) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr, combinational |
| mdio_i | input | 1 | MDIO line as seen at the pad |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value driven when mdio_oe is 1 |
| mdio_oe | output | 1 | MDIO output enable |

## Verification
The bench builds the block with HALF_DIV set to 4, so a full 64-bit frame takes about 520 system clocks. This keeps several write and read frames, a failed read, an MDC disable interval and a mid-frame abort inside one short run. The default of 50 sets only the divider's count limit. The small ratio still keeps the alignment between a start request and the next falling MDC edge, and the exact clearing cycle of the start bit, observable at every edge case.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int FRAME_BITS = 64;
    localparam int TA_FIRST   = 46;    // first bit index released on a read
    localparam int TA_LAST    = 47;    // PHY must drive 0 here
    localparam int ADDR_W     = 4;
    localparam int DATA_W     = 8;

    localparam logic [ADDR_W-1:0] A_CMD0 = 4'h0;
    localparam logic [ADDR_W-1:0] A_CMD1 = 4'h1;
    localparam logic [ADDR_W-1:0] A_CMD2 = 4'h2;
    localparam logic [ADDR_W-1:0] A_CMD3 = 4'h3;
    localparam logic [ADDR_W-1:0] A_STS0 = 4'h4;
    localparam logic [ADDR_W-1:0] A_STS1 = 4'h5;
    localparam logic [ADDR_W-1:0] A_STS2 = 4'h6;
    localparam logic [ADDR_W-1:0] A_STS3 = 4'h7;
    localparam logic [ADDR_W-1:0] A_CTRL = 4'h8;

    localparam int CTRL_RST_BIT = 0;
    localparam int CTRL_MDC_BIT = 4;
    localparam int GO_BIT       = 7;
    localparam int WR_BIT       = 2;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_ALIGN,
        SEQ_RUN
    } seq_state_e;

    typedef struct packed {
        logic        wr;
        logic [4:0]  phy;
        logic [4:0]  regad;
        logic [15:0] wdata;
    } mdio_cmd_t;

    // Bit k of the frame goes out as frame[FRAME_BITS-1-k].
    function automatic logic [FRAME_BITS-1:0] build_frame(mdio_cmd_t c);
        return {32'hFFFF_FFFF, 2'b01, (c.wr ? 2'b01 : 2'b10), c.phy, c.regad,
                2'b10, (c.wr ? c.wdata : 16'hFFFF)};
    endfunction
endpackage

// File: rtl/mdio_mdc_div.sv
module mdio_mdc_div #(
    parameter int HALF_DIV = 50
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic mdc,
    output logic rise_tick,
    output logic fall_tick
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LIMIT = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt;
    logic          wrap;

    assign wrap      = run && (cnt == LIMIT);
    assign rise_tick = wrap && !mdc;
    assign fall_tick = wrap && mdc;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (cnt == LIMIT) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end

    // R3: MDC is parked low one clock after the divider is stopped
    a_r3_low_when_off: assert property (@(posedge clk) disable iff (rst)
        !run |=> !mdc);

    // R3: MDC only moves on a divider wrap or when stopped
    a_r3_toggle_on_tick: assert property (@(posedge clk) disable iff (rst)
        !$stable(mdc) |-> ($past(rise_tick) || $past(fall_tick) || !$past(run)));
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
    import mdio_mgmt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        abort,
    input  logic        start,
    input  mdio_cmd_t   cmd,
    input  logic        rise_tick,
    input  logic        fall_tick,
    input  logic        mdc,
    input  logic        mdio_i,
    output logic        busy,
    output logic        mdio_o,
    output logic        mdio_oe,
    output logic [15:0] rd_data,
    output logic        rd_fail
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int IW = $clog2(FRAME_BITS);
    localparam logic [IW-1:0] LAST_IDX = IW'(FRAME_BITS - 1);

    seq_state_e              state;
    logic [IW-1:0]           bit_idx;
    logic [FRAME_BITS-1:0]   frame;

    assign frame   = build_frame(cmd);
    assign busy    = (state != SEQ_IDLE);
    assign mdio_oe = (state == SEQ_RUN) && (cmd.wr || (bit_idx < IW'(TA_FIRST)));
    assign mdio_o  = mdio_oe ? frame[LAST_IDX - bit_idx] : 1'b0;

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            state   <= SEQ_IDLE;
            bit_idx <= '0;
        end else begin
            unique case (state)
                SEQ_IDLE: if (start) begin
                    state   <= SEQ_ALIGN;
                    bit_idx <= '0;
                end
                SEQ_ALIGN: if (fall_tick) state <= SEQ_RUN;
                SEQ_RUN: if (fall_tick) begin
                    if (bit_idx == LAST_IDX) state <= SEQ_IDLE;
                    else                     bit_idx <= bit_idx + IW'(1);
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
            rd_fail <= 1'b0;
        end else if (state == SEQ_ALIGN && !cmd.wr) begin
            rd_fail <= 1'b0;
        end else if (state == SEQ_RUN && rise_tick && !cmd.wr && !abort) begin
            if (bit_idx == IW'(TA_LAST))
                rd_fail <= mdio_i;
            else if (bit_idx > IW'(TA_LAST))
                rd_data <= {rd_data[14:0], mdio_i};
        end
    end

    // R10: the line only moves on a falling MDC edge
    a_r10_stable_while_high: assert property (@(posedge clk) disable iff (rst)
        (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

    // R7: a frame that is not aborted ends only after its last bit
    a_r7_done_after_last: assert property (@(posedge clk) disable iff (rst)
        ($past(state) == SEQ_RUN && state == SEQ_IDLE && !$past(abort))
        |-> ($past(bit_idx) == LAST_IDX));
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
    import mdio_mgmt_pkg::*;
#(
    parameter int HALF_DIV = 50
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              mdio_i,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe
);
    timeunit 1ns;
    timeprecision 1ps;

    mdio_cmd_t   cmd;
    logic        ctrl_mdc_en;
    logic        ctrl_rst;
    logic        busy;
    logic        start;
    logic        run;
    logic        rise_tick;
    logic        fall_tick;
    logic [15:0] rd_data;
    logic        rd_fail;

    assign run   = ctrl_mdc_en && !ctrl_rst;
    assign start = reg_wr && (reg_addr == A_CMD3) && reg_wdata[GO_BIT] && !busy && !ctrl_rst;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd         <= '0;
            ctrl_mdc_en <= 1'b1;
            ctrl_rst    <= 1'b0;
        end else if (reg_wr) begin
            unique case (reg_addr)
                A_CMD0: if (!busy) cmd.wdata[7:0]  <= reg_wdata;
                A_CMD1: if (!busy) cmd.wdata[15:8] <= reg_wdata;
                A_CMD2: if (!busy) begin
                    cmd.regad    <= reg_wdata[4:0];
                    cmd.phy[2:0] <= reg_wdata[7:5];
                end
                A_CMD3: if (!busy) begin
                    cmd.phy[4:3] <= reg_wdata[1:0];
                    cmd.wr       <= reg_wdata[WR_BIT];
                end
                A_CTRL: begin
                    ctrl_mdc_en <= reg_wdata[CTRL_MDC_BIT];
                    ctrl_rst    <= reg_wdata[CTRL_RST_BIT];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (reg_addr)
            A_CMD0:  reg_rdata = cmd.wdata[7:0];
            A_CMD1:  reg_rdata = cmd.wdata[15:8];
            A_CMD2:  reg_rdata = {cmd.phy[2:0], cmd.regad};
            A_CMD3:  reg_rdata = {busy, 4'b0000, cmd.wr, cmd.phy[4:3]};
            A_STS0:  reg_rdata = rd_data[7:0];
            A_STS1:  reg_rdata = rd_data[15:8];
            A_STS2:  reg_rdata = 8'h00;
            A_STS3:  reg_rdata = {rd_fail, 7'b0};
            A_CTRL:  reg_rdata = {3'b000, ctrl_mdc_en, 3'b000, ctrl_rst};
            default: reg_rdata = 8'h00;
        endcase
    end

    mdio_mdc_div #(.HALF_DIV(HALF_DIV)) div_i (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_frame_seq seq_i (
        .clk       (clk),
        .rst       (rst),
        .abort     (ctrl_rst),
        .start     (start),
        .cmd       (cmd),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .mdc       (mdc),
        .mdio_i    (mdio_i),
        .busy      (busy),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .rd_data   (rd_data),
        .rd_fail   (rd_fail)
    );

    // R8: the command is frozen for the whole frame
    a_r8_cmd_frozen: assert property (@(posedge clk) disable iff (rst)
        $past(busy) |-> $stable(cmd));
endmodule

// File: tb/mdio_mgmt_ctrl_tb_top.sv
module mdio_mgmt_ctrl_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int H = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       mdio_i = 1'b1;
    logic       mdc, mdio_o, mdio_oe;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    always #2 clk = ~clk;

    mdio_mgmt_ctrl #(.HALF_DIV(H)) dut_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdio_i(mdio_i),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // MDC reference: integer half-period counter driven by the bench's own writes
    int  m_cnt = 0;
    bit  m_mdc = 0;
    bit  m_en  = 1;
    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_mdc = 0; m_en = 1;
        end else begin
            if (m_en) begin
                if (m_cnt == H - 1) begin m_cnt = 0; m_mdc = !m_mdc; end
                else m_cnt++;
            end else begin
                m_cnt = 0; m_mdc = 0;
            end
            if (reg_wr && reg_addr == 4'h8) m_en = reg_wdata[4] && !reg_wdata[0];
        end
    end

    // PHY responder and frame capture
    logic [63:0] resp = '1;
    logic [63:0] cap_o, cap_oe;
    int          cap_n = 0;
    bit          cap_on = 0;
    logic        p_mdc = 0, p_o = 0, p_oe = 0;

    always @(negedge clk) begin
        if (!rst) begin
            check(mdc === m_mdc, "R3", "mdc vs reference", 64'(mdc), 64'(m_mdc));
            if (mdc && p_mdc)
                check(mdio_o === p_o && mdio_oe === p_oe, "R10", "mdio moved while mdc high",
                      {62'b0, mdio_oe, mdio_o}, {62'b0, p_oe, p_o});
            if (mdc && !p_mdc && cap_on && cap_n < 64 && (cap_n > 0 || mdio_oe)) begin
                cap_o[63 - cap_n]  = mdio_o;
                cap_oe[63 - cap_n] = mdio_oe;
                cap_n++;
                mdio_i = (cap_n < 64) ? resp[63 - cap_n] : 1'b1;
            end
        end
        p_mdc = mdc; p_o = mdio_o; p_oe = mdio_oe;
    end

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] v);
        reg_addr = a;
        #0.2;
        v = reg_rdata;
    endtask

    function automatic logic [63:0] exp_frame(input bit w, input logic [4:0] phy,
                                              input logic [4:0] ra, input logic [15:0] d);
        logic [1:0] op = w ? 2'b01 : 2'b10;
        return {32'hFFFF_FFFF, 2'b01, op, phy, ra, 2'b10, d};
    endfunction

    task automatic start_frame(input bit w, input logic [4:0] phy, input logic [4:0] ra,
                               input logic [15:0] d, input bit ta0, input logic [15:0] rdata);
        resp = '1;
        if (!w) begin
            resp[16]   = ta0;
            resp[15:0] = rdata;
        end
        cap_n = 0; cap_o = '0; cap_oe = '0; mdio_i = 1'b1; cap_on = 1;
        wr(4'h0, d[7:0]);
        wr(4'h1, d[15:8]);
        wr(4'h2, {phy[2:0], ra});
        wr(4'h3, {1'b1, 4'b0, w, phy[4:3]});
    endtask

    task automatic finish_frame();
        logic [7:0] v;
        int t = 0;
        while (cap_n < 64 && t < 5000) begin
            @(negedge clk); #0.2; t++;
        end
        check(cap_n == 64, "R7", "MDC periods in frame", 64'(cap_n), 64'd64);
        rd(4'h3, v);
        check(v[7] == 1'b1, "R7", "start bit at last rising edge", 64'(v[7]), 64'd1);
        repeat (H - 1) @(negedge clk);
        #0.2; rd(4'h3, v);
        check(v[7] == 1'b1, "R7", "start bit one clock before end", 64'(v[7]), 64'd1);
        @(negedge clk);
        #0.2; rd(4'h3, v);
        check(v[7] == 1'b0, "R7", "start bit cleared at end", 64'(v[7]), 64'd0);
        check(mdio_oe == 1'b0, "R7", "oe after frame", 64'(mdio_oe), 64'd0);
        cap_on = 0;
    endtask

    task automatic measure_mdc();
        int t_hi = 0, t_per = 0;
        logic prev;
        prev = mdc;
        while (!(mdc && !prev)) begin prev = mdc; @(negedge clk); end
        prev = mdc;
        @(negedge clk);
        while (!(mdc && !prev)) begin
            if (mdc) t_hi++;
            t_per++; prev = mdc; @(negedge clk);
        end
        t_per++;
        check(t_per == 2 * H, "R3", "MDC period in clocks", 64'(t_per), 64'(2 * H));
        check(t_hi + 1 == H, "R3", "MDC high time in clocks", 64'(t_hi + 1), 64'(H));
    endtask

    localparam logic [63:0] RD_OE = 64'hFFFF_FFFF_FFFC_0000;

    initial begin
        logic [7:0] v;
        repeat (5) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #0.2;
        // R1 reset state
        rd(4'h3, v); check(v == 8'h00, "R1", "cmd byte3 after reset", 64'(v), 64'h00);
        rd(4'h2, v); check(v == 8'h00, "R1", "cmd byte2 after reset", 64'(v), 64'h00);
        rd(4'h4, v); check(v == 8'h00, "R1", "status0 after reset", 64'(v), 64'h00);
        rd(4'h5, v); check(v == 8'h00, "R1", "status1 after reset", 64'(v), 64'h00);
        rd(4'h7, v); check(v == 8'h00, "R1", "status3 after reset", 64'(v), 64'h00);
        rd(4'h8, v); check(v == 8'h10, "R1", "control after reset", 64'(v), 64'h10);
        check(mdio_oe == 1'b0, "R1", "oe after reset", 64'(mdio_oe), 64'd0);

        // R3 divider period
        measure_mdc();

        // R2 command readback without start
        wr(4'h0, 8'h34); wr(4'h1, 8'h12); wr(4'h2, 8'hAD); wr(4'h3, 8'h7E);
        #0.2;
        rd(4'h0, v); check(v == 8'h34, "R2", "cmd byte0", 64'(v), 64'h34);
        rd(4'h1, v); check(v == 8'h12, "R2", "cmd byte1", 64'(v), 64'h12);
        rd(4'h2, v); check(v == 8'hAD, "R2", "cmd byte2", 64'(v), 64'hAD);
        rd(4'h3, v); check(v == 8'h06, "R2", "cmd byte3 unused bits", 64'(v), 64'h06);

        // R4 write frame with R8 interfering writes
        start_frame(1'b1, 5'b10110, 5'b01101, 16'hA53C, 1'b0, 16'h0);
        repeat (20) @(negedge clk);
        #0.2; rd(4'h3, v); check(v == 8'h86, "R7", "byte3 while busy", 64'(v), 64'h86);
        wr(4'h2, 8'h00); wr(4'h0, 8'hFF);
        #0.2;
        rd(4'h2, v); check(v == 8'hCD, "R8", "byte2 write while busy ignored", 64'(v), 64'hCD);
        rd(4'h0, v); check(v == 8'h3C, "R8", "byte0 write while busy ignored", 64'(v), 64'h3C);
        finish_frame();
        check(cap_o == exp_frame(1'b1, 5'b10110, 5'b01101, 16'hA53C), "R4", "write frame bits",
              cap_o, exp_frame(1'b1, 5'b10110, 5'b01101, 16'hA53C));
        check(cap_oe == '1, "R4", "write frame oe", cap_oe, '1);

        // R5 good read
        start_frame(1'b0, 5'b00011, 5'b11111, 16'h0, 1'b0, 16'hBEEF);
        finish_frame();
        check(cap_oe == RD_OE, "R5", "read frame oe", cap_oe, RD_OE);
        check((cap_o & RD_OE) == (exp_frame(1'b0, 5'b00011, 5'b11111, 16'h0) & RD_OE), "R5",
              "read frame header", cap_o & RD_OE, exp_frame(1'b0, 5'b00011, 5'b11111, 16'h0) & RD_OE);
        rd(4'h4, v); check(v == 8'hEF, "R5", "read data low", 64'(v), 64'hEF);
        rd(4'h5, v); check(v == 8'hBE, "R5", "read data high", 64'(v), 64'hBE);
        rd(4'h7, v); check(v == 8'h00, "R6", "no fail on good read", 64'(v), 64'h00);

        // R6 failed read
        start_frame(1'b0, 5'b00001, 5'b00010, 16'h0, 1'b1, 16'h1234);
        finish_frame();
        rd(4'h7, v); check(v == 8'h80, "R6", "fail flag set", 64'(v), 64'h80);
        rd(4'h4, v); check(v == 8'h34, "R5", "data after failed read", 64'(v), 64'h34);

        // R6 write frame leaves flag, next good read clears it
        start_frame(1'b1, 5'b00100, 5'b00001, 16'h5A5A, 1'b0, 16'h0);
        finish_frame();
        rd(4'h7, v); check(v == 8'h80, "R6", "flag kept across write", 64'(v), 64'h80);
        start_frame(1'b0, 5'b00001, 5'b00010, 16'h0, 1'b0, 16'h0F0F);
        finish_frame();
        rd(4'h7, v); check(v == 8'h00, "R6", "flag cleared by read", 64'(v), 64'h00);
        rd(4'h5, v); check(v == 8'h0F, "R5", "second read high", 64'(v), 64'h0F);

        // R3 MDC disabled
        wr(4'h8, 8'hEE);
        #0.2; rd(4'h8, v); check(v == 8'h00, "R3", "control unused bits", 64'(v), 64'h00);
        repeat (30) @(negedge clk);
        check(mdc == 1'b0, "R3", "mdc held low when disabled", 64'(mdc), 64'd0);
        wr(4'h8, 8'h10);

        // R9 abort mid-frame
        start_frame(1'b0, 5'b11111, 5'b10101, 16'h0, 1'b0, 16'hC3C3);
        repeat (100) @(negedge clk);
        wr(4'h8, 8'h11);
        @(negedge clk); #0.2;
        cap_on = 0;
        rd(4'h3, v); check(v[7] == 1'b0, "R9", "start bit after abort", 64'(v[7]), 64'd0);
        check(mdio_oe == 1'b0, "R9", "oe after abort", 64'(mdio_oe), 64'd0);
        check(mdc == 1'b0, "R9", "mdc after abort", 64'(mdc), 64'd0);
        wr(4'h3, 8'h80);
        repeat (3) @(negedge clk);
        #0.2; rd(4'h3, v); check(v == 8'h00, "R9", "start ignored in core reset", 64'(v), 64'h00);
        wr(4'h8, 8'h10);
        start_frame(1'b1, 5'b01010, 5'b10011, 16'h8001, 1'b0, 16'h0);
        finish_frame();
        check(cap_o == exp_frame(1'b1, 5'b01010, 5'b10011, 16'h8001), "R9", "frame after abort",
              cap_o, exp_frame(1'b1, 5'b01010, 5'b10011, 16'h8001));

        repeat (10) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule